// File: doc/BRIEF.md
# Two-Gate Periodic Drive Pulse Generator

This block produces single periods of a two-phase gate waveform for a piezo actuator bridge. A prescaler divides the system clock by 4, 2 or 1. Each divided tick advances a period counter. Three programmed edge positions split the period into a gate A window and a gate B window. Each window is then mapped onto two bridge outputs. Every output is either driven high, driven low, or released. The mapping depends on a direction bit and on a gate-mode bit. The gate-mode bit chooses whether the gap phases brake the bridge or release it.

A controller above this block decides how many periods to run and which edge set to supply. It pulses `start_req` once per period it wants. A request made while a period is running is queued, so the next period follows the current one with no gap. The block reports each finished period with a one-cycle `period_done` pulse. All programmed values are captured when a period begins. A change made during a period therefore only affects the next period.

Top module: `piezo_gate_pulser`

## Requirements
- R1: A period lasts `period_len`+1 divided ticks, with the count running 0 to `period_len`. `period_done` is high for one clock cycle after the final tick.
- R2: `div_sel` sets the tick rate: 2'b00 gives one tick every 4 clocks, 2'b01 every 2 clocks, and 2'b10 or 2'b11 one tick every clock.
- R3: Gate A is active for counts 1 through `edge_a_end`-1, which is `edge_a_end`-1 ticks. With a period of 129, an A end of 21, a B start of 24 and a B end of 54, this gives 20 ticks of A and 30 ticks of B.
- R4: Gate B is active for counts from `edge_b_on` through `edge_b_off`-1. Where the A and B windows overlap, A wins. Counts beyond `period_len` are never reached.
- R5: With `dir_macro`=0, gate A is forward (OUT1 driven high, OUT2 driven low) and gate B is reverse (OUT1 driven low, OUT2 driven high). With `dir_macro`=1 the two are swapped. Both outputs are never driven high together.
- R6: While `b_inhibit` is captured as 1, gate B is never asserted during the period.
- R7: The idle phase applies inside a period and outside periods. With `gate_mode`=0 it is braking: both outputs are driven low (`oe`=1, `lvl`=0). With `gate_mode`=1 it is wait: both outputs are released (`oe`=0).
- R8: The period length, edge positions, inhibit, direction and mode are captured when a period starts. A change during a period affects only the next period.
- R9: If `start_req` arrives while idle, the period begins on the next tick. If it arrives while a period runs, one request is queued, and the next period starts right on the final tick, so consecutive `period_done` pulses are (`period_len`+1) × ratio clocks apart.
- R10: When `run_en` is low, the prescaler is cleared, any running period and any queued request are dropped, the outputs go idle, `start_req` is ignored and no `period_done` is produced.
- R11: During reset the outputs show the idle state of the live `gate_mode`, and `period_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enables the prescaler and the period generator |
| div_sel | input | 2 | Tick divider select |
| start_req | input | 1 | One-cycle request to run one period |
| period_len | input | 8 | Last count of the period |
| edge_a_end | input | 8 | Count at which gate A ends (active count + 1) |
| edge_b_on | input | 8 | First count of gate B |
| edge_b_off | input | 8 | Count at which gate B ends |
| b_inhibit | input | 1 | Suppresses gate B for the period |
| dir_macro | input | 1 | Swaps the gate-to-output mapping |
| gate_mode | input | 1 | Idle phase: 0 brake, 1 release |
| out1_lvl | output | 1 | OUT1 drive level |
| out1_oe | output | 1 | OUT1 driven (1) or released (0) |
| out2_lvl | output | 1 | OUT2 drive level |
| out2_oe | output | 1 | OUT2 driven (1) or released (0) |
| period_done | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench targets window boundaries that are easy to get off by one:
- An A end of 1 must give no gate A at all. A design that counted from zero would add one extra forward tick here.
- B windows that overlap A must lose the overlapping counts. B windows that run past the period end must be cut at the last count.

Back-to-back periods at every divider ratio measure the spacing between `period_done` pulses. A design that lost the queued request, or inserted an idle tick between periods, would show a wrong spacing.

Further checks cover the following cases:
- An edge register rewritten mid-period must leave the current period unchanged.
- Dropping `run_en` mid-period must go idle at once and must not resume afterwards.
- The brake and release idle patterns are checked inside the gaps of each period, where a design that confused the two modes would fail.

// File: rtl/piezo_drv_pkg.sv
// Shared types for the two-gate drive pulse generator.
// Assumes: one clock domain; the phase encoding is internal to the block.
package piezo_drv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_A    = 2'd1,
        PH_B    = 2'd2
    } phase_e;

    localparam logic [1:0] DIV_BY4 = 2'b00;
    localparam logic [1:0] DIV_BY2 = 2'b01;
endpackage

// File: rtl/gate_prescaler.sv
// Divides the system clock into count ticks: by 4, by 2 or by 1.
// Assumes: the counter is cleared while disabled. The first tick arrives
// after a full ratio of enabled clocks.
module gate_prescaler #(
    parameter int SEL_W = 2,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    import piezo_drv_pkg::*;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] last_val;

    // Select the last count value for the chosen ratio.
    always_comb begin
        unique case (sel)
            DIV_BY4: last_val = DIV_W'(3);
            DIV_BY2: last_val = DIV_W'(1);
            default: last_val = '0;
        endcase
    end

    assign tick = en && (div_cnt >= last_val);

    // Advance the divider and wrap it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      div_cnt <= '0;
        else if (tick)          div_cnt <= '0;
        else                    div_cnt <= div_cnt + 1'b1;
    end

    AST_QUARTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel == DIV_BY4 && tick) ##1 (sel == DIV_BY4) |-> !tick); // R2
endmodule

// File: rtl/gate_sequencer.sv
// Runs the period counter and captures the settings at each period start.
// It decodes the count into gate A, gate B or idle.
// Assumes: one request can be queued; edge values are in tick units.
module gate_sequencer #(
    parameter int CW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  tick,
    input  logic                  start,
    input  logic [CW-1:0]         per,
    input  logic [CW-1:0]         a_end,
    input  logic [CW-1:0]         b_on,
    input  logic [CW-1:0]         b_off,
    input  logic                  inh,
    input  logic                  dir,
    input  logic                  mode,
    output logic                  active,
    output piezo_drv_pkg::phase_e phase,
    output logic                  dir_q,
    output logic                  mode_q,
    output logic                  done
);
    import piezo_drv_pkg::*;

    logic [CW-1:0] cnt, per_q, a_end_q, b_on_q, b_off_q;
    logic          inh_q, pend;
    logic          want, last, load;

    assign want = en && (pend || start);
    assign last = active && tick && (cnt == per_q);
    assign load = tick && want && (!active || cnt == per_q);

    // Period state: active flag, count, queued request and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active <= 1'b0;
            cnt    <= '0;
            pend   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= last;
            pend <= load ? 1'b0 : want;
            if (load) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (last) begin
                active <= 1'b0;
            end else if (active && tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Capture the settings at the start of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q   <= '0;
            a_end_q <= '0;
            b_on_q  <= '0;
            b_off_q <= '0;
            inh_q   <= 1'b0;
            dir_q   <= 1'b0;
            mode_q  <= 1'b0;
        end else if (load) begin
            per_q   <= per;
            a_end_q <= a_end;
            b_on_q  <= b_on;
            b_off_q <= b_off;
            inh_q   <= inh;
            dir_q   <= dir;
            mode_q  <= mode;
        end
    end

    // Decode the count into a gate phase; gate A has priority.
    always_comb begin
        if (!active)
            phase = PH_IDLE;
        else if (cnt != '0 && cnt < a_end_q)
            phase = PH_A;
        else if (!inh_q && cnt >= b_on_q && cnt < b_off_q)
            phase = PH_B;
        else
            phase = PH_IDLE;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt <= per_q); // R1
    AST_DONE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active || cnt == '0)); // R9
    AST_NO_A_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_A) |-> cnt != '0); // R3
    AST_INHIBIT_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (active && inh_q) |-> phase != PH_B); // R6
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!active && !done)); // R10
endmodule

// File: rtl/bridge_mapper.sv
// Maps the gate phase onto the two bridge outputs, using direction and mode.
// Assumes: a released output has oe=0; idle braking drives both outputs low.
module bridge_mapper (
    input  piezo_drv_pkg::phase_e phase,
    input  logic                  dir,
    input  logic                  mode,
    output logic                  o1_lvl,
    output logic                  o1_oe,
    output logic                  o2_lvl,
    output logic                  o2_oe
);
    import piezo_drv_pkg::*;

    logic fwd, rev;

    assign fwd = (phase == PH_A && !dir) || (phase == PH_B && dir);
    assign rev = (phase == PH_A && dir)  || (phase == PH_B && !dir);

    // Pick the output pattern: forward, reverse, brake or release.
    always_comb begin
        if (fwd) begin
            o1_lvl = 1'b1; o1_oe = 1'b1; o2_lvl = 1'b0; o2_oe = 1'b1;
        end else if (rev) begin
            o1_lvl = 1'b0; o1_oe = 1'b1; o2_lvl = 1'b1; o2_oe = 1'b1;
        end else begin
            o1_lvl = 1'b0; o1_oe = !mode; o2_lvl = 1'b0; o2_oe = !mode;
        end
    end

    // Guard against both sides driven high.
    always_comb begin
        AST_NO_BOTH_HIGH: assert (!(o1_oe && o2_oe && o1_lvl && o2_lvl)); // R5
    end
endmodule

// File: rtl/piezo_gate_pulser.sv
// Top level of the two-gate drive pulse generator: prescaler, period
// sequencer and bridge mapper. Outside a period, the idle pattern follows
// the live gate_mode; inside a period it follows the captured mode.
module piezo_gate_pulser #(
    parameter int CW    = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             start_req,
    input  logic [CW-1:0]    period_len,
    input  logic [CW-1:0]    edge_a_end,
    input  logic [CW-1:0]    edge_b_on,
    input  logic [CW-1:0]    edge_b_off,
    input  logic             b_inhibit,
    input  logic             dir_macro,
    input  logic             gate_mode,
    output logic             out1_lvl,
    output logic             out1_oe,
    output logic             out2_lvl,
    output logic             out2_oe,
    output logic             period_done
);
    import piezo_drv_pkg::*;

    localparam int DIV_W = 2;

    logic   tick, active, dir_q, mode_q, mode_eff;
    phase_e phase;

    gate_prescaler #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(run_en), .sel(div_sel), .tick(tick)
    );

    gate_sequencer #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick), .start(start_req),
        .per(period_len), .a_end(edge_a_end), .b_on(edge_b_on),
        .b_off(edge_b_off), .inh(b_inhibit), .dir(dir_macro), .mode(gate_mode),
        .active(active), .phase(phase), .dir_q(dir_q), .mode_q(mode_q),
        .done(period_done)
    );

    assign mode_eff = active ? mode_q : gate_mode;

    bridge_mapper u_map (
        .phase(phase), .dir(dir_q), .mode(mode_eff),
        .o1_lvl(out1_lvl), .o1_oe(out1_oe), .o2_lvl(out2_lvl), .o2_oe(out2_oe)
    );
endmodule

// File: tb/tb_piezo_gate_pulser.sv
module tb_piezo_gate_pulser;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int V_DIV [NV] = '{2, 0, 1, 3, 2, 2};
    localparam int V_PER [NV] = '{9, 5, 7, 4, 6, 129};
    localparam int V_AE  [NV] = '{4, 2, 3, 1, 3, 21};
    localparam int V_BON [NV] = '{6, 3, 2, 2, 4, 24};
    localparam int V_BOF [NV] = '{9, 5, 6, 200, 6, 54};
    localparam int V_INH [NV] = '{0, 0, 0, 0, 1, 0};
    localparam int V_DIR [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int V_MOD [NV] = '{0, 1, 1, 0, 0, 1};

    logic clk = 0, rst_n = 0, run_en = 0, start_req = 0;
    logic [1:0] div_sel = 2'b10;
    logic [7:0] period_len = 0, edge_a_end = 0, edge_b_on = 0, edge_b_off = 0;
    logic b_inhibit = 0, dir_macro = 0, gate_mode = 0;
    logic out1_lvl, out1_oe, out2_lvl, out2_oe, period_done;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piezo_gate_pulser dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel),
        .start_req(start_req), .period_len(period_len), .edge_a_end(edge_a_end),
        .edge_b_on(edge_b_on), .edge_b_off(edge_b_off), .b_inhibit(b_inhibit),
        .dir_macro(dir_macro), .gate_mode(gate_mode), .out1_lvl(out1_lvl),
        .out1_oe(out1_oe), .out2_lvl(out2_lvl), .out2_oe(out2_oe),
        .period_done(period_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_fwd();
        return out1_oe && out2_oe && out1_lvl && !out2_lvl;
    endfunction
    function automatic bit is_rev();
        return out1_oe && out2_oe && !out1_lvl && out2_lvl;
    endfunction
    function automatic bit is_idle(input bit m);
        return m ? (!out1_oe && !out2_oe) : (out1_oe && out2_oe && !out1_lvl && !out2_lvl);
    endfunction
    function automatic int ratio(input int s);
        return (s == 0) ? 4 : (s == 1) ? 2 : 1;
    endfunction

    // Runs one period, or two if second_at >= 0, and classifies every sample.
    task automatic measure(input int second_at, input int chg_at, input int chg_val,
                           input bit m, output int nf, output int nr, output int nbad,
                           output int gap, output int ndone);
        int d1;
        d1 = 0; nf = 0; nr = 0; nbad = 0; gap = 0; ndone = 0;
        @(negedge clk) start_req = 1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start_req = (cyc == second_at);
            if (cyc == chg_at) edge_a_end = 8'(chg_val);
            if (is_fwd()) nf++;
            else if (is_rev()) nr++;
            else if (!is_idle(m)) nbad++;
            if (period_done) begin
                ndone++;
                if (ndone == 1) d1 = cyc;
                else begin gap = cyc - d1; break; end
                if (second_at < 0) break;
            end
        end
        start_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nf, nr, nbad, gap, ndone, ea, eb, r;
        // R11 / R7: outputs during reset
        repeat (3) @(negedge clk);
        check(is_idle(0) && !period_done, "R11 reset brake idle", {out1_oe, out2_oe}, 3);
        gate_mode = 1;
        @(negedge clk);
        check(is_idle(1), "R7 reset release idle", {out1_oe, out2_oe}, 0);
        rst_n = 1; run_en = 1;

        // Vector table: two back-to-back periods per entry
        for (int v = 0; v < NV; v++) begin
            div_sel = 2'(V_DIV[v]); period_len = 8'(V_PER[v]);
            edge_a_end = 8'(V_AE[v]); edge_b_on = 8'(V_BON[v]); edge_b_off = 8'(V_BOF[v]);
            b_inhibit = V_INH[v][0]; dir_macro = V_DIR[v][0]; gate_mode = V_MOD[v][0];
            r = ratio(V_DIV[v]);
            ea = 0; eb = 0;
            for (int c = 0; c <= V_PER[v]; c++) begin
                if (c >= 1 && c < V_AE[v]) ea++;
                else if (V_INH[v] == 0 && c >= V_BON[v] && c < V_BOF[v]) eb++;
            end
            ea = ea * r * 2; eb = eb * r * 2;
            measure(2 * r + 2, -1, 0, V_MOD[v][0], nf, nr, nbad, gap, ndone);
            if (V_DIR[v] == 0) begin
                check(nf == ea, "R3 gate A forward ticks", nf, ea);
                check(nr == eb, "R4 R6 gate B reverse ticks", nr, eb);
            end else begin
                check(nr == ea, "R5 gate A reverse when swapped", nr, ea);
                check(nf == eb, "R5 gate B forward when swapped", nf, eb);
            end
            check(gap == r * (V_PER[v] + 1), "R1 R2 R9 done spacing", gap, r * (V_PER[v] + 1));
            check(nbad == 0, "R7 idle pattern inside period", nbad, 0);
            @(negedge clk);
            check(is_idle(V_MOD[v][0]) && !period_done, "R7 idle after period", out1_oe, !V_MOD[v]);
        end

        // R8: a mid-period edit takes effect only in the next period
        div_sel = 2'b10; period_len = 9; edge_a_end = 4; edge_b_on = 0; edge_b_off = 0;
        b_inhibit = 0; dir_macro = 0; gate_mode = 0;
        measure(-1, 2, 8, 0, nf, nr, nbad, gap, ndone);
        check(nf == 3, "R8 current period keeps old edge", nf, 3);
        measure(-1, -1, 0, 0, nf, nr, nbad, gap, ndone);
        check(nf == 7, "R8 next period uses new edge", nf, 7);

        // R10: disable mid-period
        period_len = 20; edge_a_end = 15;
        @(negedge clk) start_req = 1;
        @(negedge clk) start_req = 0;
        repeat (4) @(negedge clk);
        check(is_fwd(), "R10 period running before disable", out1_lvl, 1);
        run_en = 0;
        @(negedge clk);
        check(is_idle(0) && !period_done, "R10 idle right after disable", out1_lvl, 0);
        nbad = 0;
        for (int i = 0; i < 10; i++) begin
            start_req = (i == 3);
            @(negedge clk);
            if (!is_idle(0) || period_done) nbad++;
        end
        start_req = 0;
        check(nbad == 0, "R10 start ignored while disabled", nbad, 0);
        run_en = 1; nbad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!is_idle(0) || period_done) nbad++;
        end
        check(nbad == 0, "R10 no resume after re-enable", nbad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule